// File: doc/BRIEF.md
# Flash Program/Erase Status Responder

This block models the read side of a byte-wide parallel NOR flash while an internal program or erase runs. A host writes a command through a small command port. The command takes effect on the rising edge of the active-low write strobe. From then until the operation ends, reads at addresses that the operation covers return a status byte instead of array contents. Bit 7 carries polarity-coded progress. Bit 6 flips on every completed output-enable read. Bit 5 flags an operation that ran past its time budget.

Cell storage is not modelled. Array contents come in on `arrayRdData` as a function of the current read address. The block keeps two things itself: the most recent programmed byte, and the set of erased sectors. These overlay the external data once an operation completes. Attempts on protected sectors keep the status active for a fixed interval and change nothing. The intervals are given in microseconds and converted to cycles through a clock-frequency parameter, so a bench can shrink them.

Top module: `flash_status_top`

## Requirements
- R1: A command is taken only on the cycle after `weN` goes from 0 to 1 with `cmdKind` non-zero (1 program, 2 sector erase, 3 chip erase, 4 reset). Until then, reads return array data.
- R2: While an unprotected program runs, a read at the program address gives bit 7 equal to the inverse of the datum's bit 7, bit 5 equal to 0 and bits 4..0 equal to 0.
- R3: After a program to an unprotected sector completes, a read at that address returns the whole written byte, so bit 7 is the true value.
- R4: A program into a protected sector (sector = top log2(NumSectors) address bits) shows status for ProtProgUs*ClkFreqHz/1e6 cycles. It then returns to array reads with no data change.
- R5: During an erase, bit 7 reads 0 at addresses in selected sectors. After completion, every unprotected selected sector reads 8'hFF.
- R6: An erase whose selected sectors are all protected shows status for ProtEraseUs*ClkFreqHz/1e6 cycles. It then returns to array reads with no change.
- R7: An erase that selects both protected and unprotected sectors erases only the unprotected ones. Protected sectors keep returning their previous data.
- R8: Status appears only at valid addresses: the program address, any sector in the erase selection, or for a chip erase any unprotected sector. Other addresses return normal read data during the operation.
- R9: While busy, bit 6 of the status byte inverts after each completed read (`oeN` rising). Once the block is idle, repeated reads return identical bytes.
- R10: If an operation is still busy after TimeoutCycles cycles, bit 5 sets and the operation halts. Status stays until a reset command, which returns to array reads without applying the operation.
- R11: Commands written while an operation is busy are ignored.
- R12: A program lasts ProgCycles cycles. An erase lasts EraseCycles times the number of unprotected selected sectors.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| weN | input | 1 | Active-low write strobe; its rising edge commits the command |
| oeN | input | 1 | Active-low read strobe; its rising edge ends a read |
| addr | input | AddrW | Read address |
| cmdKind | input | 3 | Command code: 0 none, 1 program, 2 sector erase, 3 chip erase, 4 reset |
| cmdAddr | input | AddrW | Program target address |
| cmdData | input | 8 | Program datum |
| cmdSel | input | NumSectors | Sectors selected for a sector erase |
| protMask | input | NumSectors | Per-sector write protection |
| arrayRdData | input | 8 | External array byte at `addr` |
| dataOut | output | 8 | Read data or status byte |

## Verification
Several properties are checked on every cycle:
- the idle state never leaves without a write-strobe rising edge;
- a busy count never reaches the time budget;
- a failed operation stays failed until a reset command arrives;
- a protected program leaves the programmed-byte record untouched;
- the data overlay stays frozen for the whole busy window.

The bench scenarios are the only way to show the externally visible behaviour: the polarity of bit 7 against the written datum, exact operation lengths for protected and partial erases, which addresses report status, bit 6 flipping across reads, and recovery after a timeout.

// File: rtl/flash_status_pkg.sv
package flash_status_pkg;

  localparam int DurW = 32;

  typedef enum logic [2:0] {
    CMD_NONE       = 3'd0,
    CMD_PROG       = 3'd1,
    CMD_SECT_ERASE = 3'd2,
    CMD_CHIP_ERASE = 3'd3,
    CMD_RESET      = 3'd4
  } cmdKindE;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_BUSY = 2'd1,
    ST_FAIL = 2'd2
  } opStateE;

  // control -> datapath strobes
  typedef struct packed {
    logic start;    // latch the command being committed
    logic finish;   // apply the operation result
    logic setFail;  // budget exceeded
    logic abort;    // drop the halted operation
    logic clrFail;  // reset command seen
  } dpStrobeT;

endpackage

// File: rtl/flash_status_ctrl.sv
module flash_status_ctrl
  import flash_status_pkg::*;
#(
  parameter int unsigned TimeoutCycles = 20_000_000
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                weRise,
  input  cmdKindE             kind,
  input  logic [DurW-1:0]     durReq,
  output dpStrobeT            strb,
  output logic                busy
);

  localparam logic [DurW-1:0] BudgetLast = DurW'(TimeoutCycles - 1);

  opStateE         state, stateNxt;
  logic [DurW-1:0] cnt;
  logic [DurW-1:0] limit;
  logic            isOpCmd;

  assign isOpCmd = (kind == CMD_PROG) || (kind == CMD_SECT_ERASE) ||
                   (kind == CMD_CHIP_ERASE);

  always_comb begin
    stateNxt = state;
    strb     = '0;
    unique case (state)
      ST_IDLE: begin
        if (weRise && isOpCmd) begin
          strb.start = 1'b1;
          stateNxt   = ST_BUSY;
        end else if (weRise && kind == CMD_RESET) begin
          strb.clrFail = 1'b1;
        end
      end
      ST_BUSY: begin
        if (cnt == limit) begin
          strb.finish = 1'b1;
          stateNxt    = ST_IDLE;
        end else if (cnt == BudgetLast) begin
          strb.setFail = 1'b1;
          stateNxt     = ST_FAIL;
        end
      end
      ST_FAIL: begin
        if (weRise && kind == CMD_RESET) begin
          strb.clrFail = 1'b1;
          strb.abort   = 1'b1;
          stateNxt     = ST_IDLE;
        end
      end
      default: stateNxt = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state <= ST_IDLE;
      cnt   <= '0;
      limit <= '0;
    end else begin
      state <= stateNxt;
      if (strb.start) begin
        cnt   <= '0;
        limit <= durReq - 1'b1;
      end else if (state == ST_BUSY) begin
        cnt <= cnt + 1'b1;
      end
    end
  end

  assign busy = (state != ST_IDLE);

  AST_IDLE_NEEDS_WE: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_IDLE && !weRise) |=> (state == ST_IDLE)); // R1

  AST_BUSY_UNDER_BUDGET: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_BUSY) |-> (cnt < DurW'(TimeoutCycles))); // R10

  AST_FAIL_WAITS_RESET: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_FAIL && !(weRise && kind == CMD_RESET)) |=> (state == ST_FAIL)); // R10

  AST_BUSY_IGNORES_CMD: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_BUSY) |-> !strb.start); // R11

endmodule

// File: rtl/flash_status_dp.sv
module flash_status_dp
  import flash_status_pkg::*;
#(
  parameter int unsigned AddrW        = 12,
  parameter int unsigned NumSectors   = 8,
  parameter int unsigned ProgCycles   = 700,
  parameter int unsigned EraseCycles  = 50_000,
  parameter int unsigned ProtProgCyc  = 200_000,
  parameter int unsigned ProtEraseCyc = 10_000_000
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  dpStrobeT              strb,
  input  logic                  busy,
  input  logic                  oeRise,
  input  cmdKindE               kind,
  input  logic [AddrW-1:0]      cmdAddr,
  input  logic [7:0]            cmdData,
  input  logic [NumSectors-1:0] cmdSel,
  input  logic [NumSectors-1:0] protMask,
  input  logic [AddrW-1:0]      addr,
  input  logic [7:0]            arrayRdData,
  output logic [DurW-1:0]       durReq,
  output logic [7:0]            dataOut
);

  localparam int unsigned SecW = $clog2(NumSectors);

  // latched operation
  cmdKindE               opKind;
  logic [AddrW-1:0]      opAddr;
  logic [7:0]            opData;
  logic [NumSectors-1:0] opValidSec;   // sectors where erase status is shown
  logic [NumSectors-1:0] opEraseSec;   // sectors actually erased
  logic                  opProt;

  // result overlay
  logic                  ovValid;
  logic [AddrW-1:0]      ovAddr;
  logic [7:0]            ovData;
  logic [NumSectors-1:0] erasedMask;

  logic                  failFlag;
  logic                  toggleBit;

  logic [SecW-1:0]       cmdSec, rdSec, ovSec;
  logic [NumSectors-1:0] selNow, effNow;
  logic                  isErase, opIsErase, statusValid;
  logic [7:0]            statusByte, arrayByte;

  assign cmdSec = cmdAddr[AddrW-1 -: SecW];
  assign rdSec  = addr[AddrW-1 -: SecW];
  assign ovSec  = ovAddr[AddrW-1 -: SecW];

  assign isErase = (kind == CMD_SECT_ERASE) || (kind == CMD_CHIP_ERASE);
  assign selNow  = (kind == CMD_CHIP_ERASE) ? {NumSectors{1'b1}} : cmdSel;
  assign effNow  = selNow & ~protMask;

  // requested duration for the command on the port
  always_comb begin
    durReq = DurW'(1);
    if (kind == CMD_PROG) begin
      durReq = protMask[cmdSec] ? DurW'(ProtProgCyc) : DurW'(ProgCycles);
    end else if (isErase) begin
      if (effNow == '0) durReq = DurW'(ProtEraseCyc);
      else              durReq = DurW'(EraseCycles) * DurW'($countones(effNow));
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      opKind     <= CMD_NONE;
      opAddr     <= '0;
      opData     <= '0;
      opValidSec <= '0;
      opEraseSec <= '0;
      opProt     <= 1'b0;
    end else if (strb.start) begin
      opKind     <= kind;
      opAddr     <= cmdAddr;
      opData     <= cmdData;
      opValidSec <= (kind == CMD_CHIP_ERASE) ? ~protMask : cmdSel;
      opEraseSec <= isErase ? effNow : '0;
      opProt     <= protMask[cmdSec];
    end else if (strb.abort || strb.finish) begin
      opKind <= CMD_NONE;
    end
  end

  assign opIsErase = (opKind == CMD_SECT_ERASE) || (opKind == CMD_CHIP_ERASE);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ovValid    <= 1'b0;
      ovAddr     <= '0;
      ovData     <= '0;
      erasedMask <= '0;
    end else if (strb.finish) begin
      if (opKind == CMD_PROG && !opProt) begin
        ovValid <= 1'b1;
        ovAddr  <= opAddr;
        ovData  <= opData;
      end else if (opIsErase) begin
        erasedMask <= erasedMask | opEraseSec;
        if (ovValid && opEraseSec[ovSec]) ovValid <= 1'b0;
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      failFlag  <= 1'b0;
      toggleBit <= 1'b0;
    end else begin
      if (strb.setFail)      failFlag <= 1'b1;
      else if (strb.clrFail) failFlag <= 1'b0;
      if (busy && oeRise) toggleBit <= ~toggleBit;
    end
  end

  // read path
  always_comb begin
    statusValid = 1'b0;
    if (opKind == CMD_PROG) statusValid = (addr == opAddr);
    else if (opIsErase)     statusValid = opValidSec[rdSec];
  end

  assign statusByte = {(opKind == CMD_PROG) ? ~opData[7] : 1'b0,
                       toggleBit, failFlag, 5'b0_0000};

  always_comb begin
    if (ovValid && addr == ovAddr) arrayByte = ovData;
    else if (erasedMask[rdSec])    arrayByte = 8'hFF;
    else                           arrayByte = arrayRdData;
  end

  assign dataOut = (busy && statusValid) ? statusByte : arrayByte;

  AST_OVERLAY_FROZEN: assert property (@(posedge clk) disable iff (!rstN)
    (busy && !strb.finish) |=> ($stable(ovValid) && $stable(ovData) && $stable(erasedMask))); // R11

  AST_PROT_PROG_KEEPS: assert property (@(posedge clk) disable iff (!rstN)
    (strb.finish && opKind == CMD_PROG && opProt)
      |=> ($stable(ovValid) && $stable(ovAddr) && $stable(ovData))); // R4

  AST_FAIL_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    (failFlag && !strb.clrFail) |=> failFlag); // R10

  AST_ERASE_HAS_VALID_SEC: assert property (@(posedge clk) disable iff (!rstN)
    (busy && opIsErase && opEraseSec != '0) |-> ((opEraseSec & ~opValidSec) == '0)); // R8

endmodule

// File: rtl/flash_status_top.sv
module flash_status_top
  import flash_status_pkg::*;
#(
  parameter int unsigned AddrW         = 12,
  parameter int unsigned NumSectors    = 8,
  parameter int unsigned ClkFreqHz     = 100_000_000,
  parameter int unsigned ProgCycles    = 700,
  parameter int unsigned EraseCycles   = 50_000,
  parameter int unsigned ProtProgUs    = 2_000,
  parameter int unsigned ProtEraseUs   = 100_000,
  parameter int unsigned TimeoutCycles = 20_000_000
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  weN,
  input  logic                  oeN,
  input  logic [AddrW-1:0]      addr,
  input  logic [2:0]            cmdKind,
  input  logic [AddrW-1:0]      cmdAddr,
  input  logic [7:0]            cmdData,
  input  logic [NumSectors-1:0] cmdSel,
  input  logic [NumSectors-1:0] protMask,
  input  logic [7:0]            arrayRdData,
  output logic [7:0]            dataOut
);

  localparam longint unsigned ProtProgL  =
    (longint'(ClkFreqHz) * longint'(ProtProgUs)) / 64'd1_000_000;
  localparam longint unsigned ProtEraseL =
    (longint'(ClkFreqHz) * longint'(ProtEraseUs)) / 64'd1_000_000;
  localparam int unsigned ProtProgCyc  = int'(ProtProgL);
  localparam int unsigned ProtEraseCyc = int'(ProtEraseL);

  logic            weNq, oeNq, weRise, oeRise, busy;
  dpStrobeT        strb;
  logic [DurW-1:0] durReq;
  cmdKindE         kind;

  assign kind = cmdKindE'(cmdKind);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      weNq <= 1'b1;
      oeNq <= 1'b1;
    end else begin
      weNq <= weN;
      oeNq <= oeN;
    end
  end

  assign weRise = weN & ~weNq;
  assign oeRise = oeN & ~oeNq;

  flash_status_ctrl #(
    .TimeoutCycles(TimeoutCycles)
  ) u_ctrl (
    .clk   (clk),
    .rstN  (rstN),
    .weRise(weRise),
    .kind  (kind),
    .durReq(durReq),
    .strb  (strb),
    .busy  (busy)
  );

  flash_status_dp #(
    .AddrW       (AddrW),
    .NumSectors  (NumSectors),
    .ProgCycles  (ProgCycles),
    .EraseCycles (EraseCycles),
    .ProtProgCyc (ProtProgCyc),
    .ProtEraseCyc(ProtEraseCyc)
  ) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .strb       (strb),
    .busy       (busy),
    .oeRise     (oeRise),
    .kind       (kind),
    .cmdAddr    (cmdAddr),
    .cmdData    (cmdData),
    .cmdSel     (cmdSel),
    .protMask   (protMask),
    .addr       (addr),
    .arrayRdData(arrayRdData),
    .durReq     (durReq),
    .dataOut    (dataOut)
  );

endmodule

// File: tb/flash_status_top_tb.sv
`timescale 1ns/1ps
module flash_status_top_tb;

  localparam int AW = 12;
  localparam int NS = 8;
  localparam int PROG = 16;
  localparam int ERS = 120;
  localparam int PPROG = 40;
  localparam int PERS = 300;
  localparam int TMO = 500;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic weN = 1'b1, oeN = 1'b1;
  logic [AW-1:0] addr = '0, cmdAddr = '0;
  logic [2:0] cmdKind = 3'd0;
  logic [7:0] cmdData = '0;
  logic [NS-1:0] cmdSel = '0, protMask = '0;
  logic [7:0] arrayRdData, dataOut;

  int nChecks = 0;
  int nErr = 0;
  bit finished = 1'b0;

  // model of the block's result overlay
  bit mOvValid = 1'b0;
  logic [AW-1:0] mOvAddr = '0;
  logic [7:0] mOvData = '0;
  logic [NS-1:0] mErased = '0;

  always #5 clk = ~clk;

  function automatic logic [7:0] arr(input logic [AW-1:0] a);
    return a[7:0] ^ {a[11:8], a[11:8]} ^ 8'h5A;
  endfunction

  assign arrayRdData = arr(addr);

  function automatic logic [7:0] expRead(input logic [AW-1:0] a);
    if (mOvValid && a == mOvAddr) return mOvData;
    if (mErased[a[AW-1 -: 3]]) return 8'hFF;
    return arr(a);
  endfunction

  flash_status_top #(
    .AddrW(AW), .NumSectors(NS), .ClkFreqHz(1_000_000),
    .ProgCycles(PROG), .EraseCycles(ERS),
    .ProtProgUs(PPROG), .ProtEraseUs(PERS), .TimeoutCycles(TMO)
  ) u_dut (
    .clk(clk), .rstN(rstN), .weN(weN), .oeN(oeN), .addr(addr),
    .cmdKind(cmdKind), .cmdAddr(cmdAddr), .cmdData(cmdData),
    .cmdSel(cmdSel), .protMask(protMask), .arrayRdData(arrayRdData),
    .dataOut(dataOut)
  );

  task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
    nChecks++;
    if (act !== exp) begin
      nErr++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic chkStat(input string tag, input logic [7:0] v, input logic b7, input logic b5);
    check(tag, v & 8'hBF, {b7, 1'b0, b5, 5'b0});
  endtask

  // called at a negedge: peek without ending a read
  task automatic peek(input logic [AW-1:0] a, output logic [7:0] v);
    addr = a;
    #1 v = dataOut;
  endtask

  task automatic oeRead(input logic [AW-1:0] a, output logic [7:0] v);
    @(negedge clk); addr = a; oeN = 1'b0;
    #1 v = dataOut;
    @(negedge clk); oeN = 1'b1;
  endtask

  // returns at sample point 1 (first negedge after the start edge)
  task automatic issue(input logic [2:0] k, input logic [AW-1:0] ca,
                       input logic [7:0] cd, input logic [NS-1:0] cs);
    @(negedge clk); weN = 1'b0; cmdKind = k; cmdAddr = ca; cmdData = cd; cmdSel = cs;
    @(negedge clk); weN = 1'b1;
    @(negedge clk); cmdKind = 3'd0;
  endtask

  task automatic advance(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic waitUntil(input logic [AW-1:0] a, input logic [7:0] exp, input string tag);
    logic [7:0] v;
    for (int i = 0; i < 2000; i++) begin
      peek(a, v);
      if (v === exp) return;
      @(negedge clk);
    end
    check(tag, v, exp);
  endtask

  initial begin
    repeat (150_000) @(posedge clk);
    if (!finished) begin
      nErr++; nChecks++;
      $display("FAIL watchdog actual=running expected=done");
      $display("Result: errors=%0d of %0d checks", nErr, nChecks);
      $finish;
    end
  end

  initial begin
    logic [7:0] v, v2;
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // reset state
    peek(12'h123, v); check("R1 reset read", v, arr(12'h123));

    // R1: nothing before the write strobe rises
    @(negedge clk); weN = 1'b0; cmdKind = 3'd1; cmdAddr = 12'h2A0; cmdData = 8'hA5;
    @(negedge clk); peek(12'h2A0, v); check("R1 before WE rise", v, arr(12'h2A0));
    weN = 1'b1;
    @(negedge clk); cmdKind = 3'd0;
    peek(12'h2A0, v); chkStat("R2 program status", v, 1'b0, 1'b0);
    advance(PROG - 1); peek(12'h2A0, v); chkStat("R12 program still busy", v, 1'b0, 1'b0);
    advance(1); peek(12'h2A0, v); check("R3 program result", v, 8'hA5);
    mOvValid = 1; mOvAddr = 12'h2A0; mOvData = 8'hA5;

    // R9 toggle, R8 other address, R11 ignored command
    issue(3'd1, 12'h2B0, 8'h3C, '0);
    peek(12'h2B0, v); chkStat("R2 program bit7 inverse of 0", v, 1'b1, 1'b0);
    oeRead(12'h2B0, v); oeRead(12'h2B0, v2);
    check("R9 bit6 flips busy", {7'b0, v[6] ^ v2[6]}, 8'h01);
    @(negedge clk); peek(12'h2A0, v); check("R8 non-status address", v, 8'hA5);
    issue(3'd1, 12'h2C0, 8'h11, '0);
    waitUntil(12'h2B0, 8'h3C, "R3 second program result");
    mOvAddr = 12'h2B0; mOvData = 8'h3C;
    @(negedge clk); peek(12'h2C0, v); check("R11 busy command ignored", v, arr(12'h2C0));
    oeRead(12'h2B0, v); oeRead(12'h2B0, v2); check("R9 idle reads stable", v2, v);

    // R4 protected program
    protMask = 8'b0000_1000;
    issue(3'd1, 12'h610, 8'h00, '0);
    peek(12'h610, v); chkStat("R4 protected program status", v, 1'b1, 1'b0);
    advance(PPROG - 1); peek(12'h610, v); chkStat("R4 protected still busy", v, 1'b1, 1'b0);
    advance(1); peek(12'h610, v); check("R4 protected unchanged", v, arr(12'h610));
    peek(12'h2B0, v); check("R4 overlay intact", v, 8'h3C);

    // R5/R7 mixed sector erase: sectors 2,3 selected, 3 protected
    issue(3'd2, '0, '0, 8'b0000_1100);
    peek(12'h410, v); chkStat("R5 erase status", v, 1'b0, 1'b0);
    peek(12'h620, v); chkStat("R8 selected protected sector status", v, 1'b0, 1'b0);
    peek(12'h810, v); check("R8 unselected sector", v, arr(12'h810));
    advance(ERS - 1); peek(12'h410, v); chkStat("R12 erase still busy", v, 1'b0, 1'b0);
    advance(1); peek(12'h410, v); check("R5 erased reads FF", v, 8'hFF);
    mErased[2] = 1'b1;
    peek(12'h620, v); check("R7 protected sector kept", v, arr(12'h620));

    // R6 all selected sectors protected
    protMask = 8'b0010_0000;
    issue(3'd2, '0, '0, 8'b0010_0000);
    peek(12'hA40, v); chkStat("R6 protected erase status", v, 1'b0, 1'b0);
    advance(PERS - 1); peek(12'hA40, v); chkStat("R6 still busy", v, 1'b0, 1'b0);
    advance(1); peek(12'hA40, v); check("R6 no change", v, arr(12'hA40));

    // R8 chip erase with sectors 6,7 unprotected
    protMask = 8'b0011_1111;
    issue(3'd3, '0, '0, '0);
    peek(12'hE20, v); chkStat("R8 chip erase valid sector", v, 1'b0, 1'b0);
    peek(12'h2B0, v); check("R8 chip erase protected sector", v, 8'h3C);
    advance(2 * ERS); peek(12'hE20, v); check("R12 chip erase result", v, 8'hFF);
    mErased[7:6] = 2'b11;

    // R10 timeout: five unprotected sectors exceed the budget
    protMask = 8'b0000_0111;
    issue(3'd3, '0, '0, '0);
    peek(12'hC10, v); chkStat("R10 no fail at start", v, 1'b0, 1'b0);
    advance(TMO - 1); peek(12'hC10, v); chkStat("R10 fail not yet", v, 1'b0, 1'b0);
    advance(1); peek(12'hC10, v); chkStat("R10 fail set", v, 1'b0, 1'b1);
    advance(400); peek(12'h810, v); chkStat("R10 halted keeps status", v, 1'b0, 1'b1);
    issue(3'd4, '0, '0, '0);
    peek(12'h810, v); check("R10 reset no erase", v, arr(12'h810));
    protMask = '0;
    issue(3'd1, 12'h850, 8'h80, '0);
    peek(12'h850, v); chkStat("R10 fail cleared", v, 1'b0, 1'b0);
    waitUntil(12'h850, 8'h80, "R3 program after reset");
    mOvAddr = 12'h850; mOvData = 8'h80;

    // random programs with random protection
    for (int i = 0; i < 20; i++) begin
      logic [AW-1:0] a;
      logic [7:0] d;
      int dur;
      a = AW'($urandom);
      d = 8'($urandom);
      protMask = NS'($urandom);
      dur = protMask[a[AW-1 -: 3]] ? PPROG : PROG;
      issue(3'd1, a, d, '0);
      peek(a, v); chkStat("R2 random status", v, ~d[7], 1'b0);
      advance(dur - 1); peek(a, v); chkStat("R12 random busy", v, ~d[7], 1'b0);
      if (!protMask[a[AW-1 -: 3]]) begin
        mOvValid = 1; mOvAddr = a; mOvData = d;
      end
      advance(1); peek(a, v); check("R3 random result", v, expRead(a));
    end

    finished = 1'b1;
    $display("Result: errors=%0d of %0d checks", nErr, nChecks);
    $finish;
  end

endmodule